// File: doc/BRIEF.md
# Random-Key Tour Decoder with Closed-Tour Cost Evaluation

This block turns one candidate solution of a routing search into a concrete tour and prices it. A candidate arrives as a stream of gene weights, one per city. The first accepted weight belongs to city 0, the next to city 1, and so on. A chain of systolic sorting cells orders the cities by ascending weight. The sorted chain is then drained one city per cycle. That stream is the visit order, and each entry is tagged with its position, which is the city's rank.

While the order streams out, the block reads a directed travel-cost table through a read port that takes a source city and a destination city as separate addresses. It adds up the cost of every leg between consecutive visited cities. It then adds the leg from the last city back to the first, and presents the total with a one-cycle completion pulse. Filling the cost table and steering the surrounding search are left to the host.

A run begins with a start pulse while the block is idle. The host then offers exactly N_CITY weights with a valid strobe, and gaps between them are allowed. The block reports busy until the completion pulse has been given.

Top module: `weight_tour_eval`

## Requirements
- R1: After reset the block is idle: busy, done, ord_valid and cost_rd_en are 0 and total_cost is 0.
- R2: A start pulse while idle opens a run. The next N_CITY cycles with in_valid high deliver the weights of cities 0, 1, 2 and onward in that order, with any number of idle cycles between them. in_valid while idle is ignored. After the weights have been taken, ord_valid is high for exactly N_CITY consecutive cycles.
- R3: The visit-order stream (ord_city) lists every city once, in ascending order of weight. Among equal weights the lower city index comes first. For example, weights 25,17,10,20,55,5,70,13 on cities 0 to 7 give the order 5,2,7,1,3,0,4,6.
- R4: ord_pos counts 0 to N_CITY-1 along the stream, so each city appears with its rank. For the example weights, the ranks of cities 0 to 7 are 5,3,1,4,6,0,7,2.
- R5: For every stream entry after the first, cost_rd_en is high in the same cycle, with cost_from set to the previous city and cost_to set to the current city. cost_rd_data is taken one cycle after cost_rd_en.
- R6: In the cycle after the last stream entry, one more read is issued, from the last visited city to the first visited city.
- R7: done is a single-cycle pulse. While done is high, total_cost equals the sum of all N_CITY leg costs, including the return leg, without overflow even when every leg costs 2^C_BITS-1. total_cost then holds its value until the next start.
- R8: A start pulse while busy has no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a run when idle |
| in_valid | input | 1 | Qualifies in_weight during loading |
| in_weight | input | W_BITS | Weight of the next city |
| busy | output | 1 | High from start until done |
| cost_rd_en | output | 1 | Cost table read strobe |
| cost_from | output | clog2(N_CITY) | Source city of the leg |
| cost_to | output | clog2(N_CITY) | Destination city of the leg |
| cost_rd_data | input | C_BITS | Leg cost, one cycle after the strobe |
| ord_valid | output | 1 | Visit-order entry valid |
| ord_city | output | clog2(N_CITY) | City visited at this position |
| ord_weight | output | W_BITS | Weight of that city |
| ord_pos | output | clog2(N_CITY) | Position in the tour, the city's rank |
| done | output | 1 | One-cycle completion pulse |
| total_cost | output | C_BITS+clog2(N_CITY+1) | Closed-tour cost |

## Verification
The hardest cases to reach are long runs of equal weights and worst-case totals. Ties force the sorting cells to settle the order by city index while items are still moving through the chain. A worst-case total needs every leg to carry the largest cost. The stimulus covers both. It uses a narrow random weight range and an all-equal candidate to create dense ties, and it switches the bench cost table to a mode where every leg returns the maximum value. Random gaps in the weight stream, stray strobes while idle and a start pulse in the middle of a run show that only the intended weights are accepted.

// File: rtl/tour_pkg.sv
package tour_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SETTLE,
      ST_EMIT,
      ST_CLOSE,
      ST_DRAIN,
      ST_FIN
   } tour_state_t;

endpackage

// File: rtl/sort_cell.sv
module sort_cell #(
   parameter int W_BITS = 8,
   parameter int IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift,
   input  logic              in_v,
   input  logic [W_BITS-1:0] in_w,
   input  logic [IDX_W-1:0]  in_i,
   input  logic              nb_v,
   input  logic [W_BITS-1:0] nb_w,
   input  logic [IDX_W-1:0]  nb_i,
   output logic              hold_v,
   output logic [W_BITS-1:0] hold_w,
   output logic [IDX_W-1:0]  hold_i,
   output logic              pass_v,
   output logic [W_BITS-1:0] pass_w,
   output logic [IDX_W-1:0]  pass_i
);

   logic in_less;

   always_comb begin
      in_less = (in_w < hold_w) || ((in_w == hold_w) && (in_i < hold_i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_w <= '0;
         hold_i <= '0;
         pass_v <= 1'b0;
         pass_w <= '0;
         pass_i <= '0;
      end else if (clr) begin
         hold_v <= 1'b0;
         pass_v <= 1'b0;
      end else if (shift) begin
         hold_v <= nb_v;
         hold_w <= nb_w;
         hold_i <= nb_i;
         pass_v <= 1'b0;
      end else begin
         pass_v <= 1'b0;
         if (in_v) begin
            if (!hold_v) begin
               hold_v <= 1'b1;
               hold_w <= in_w;
               hold_i <= in_i;
            end else if (in_less) begin
               hold_w <= in_w;
               hold_i <= in_i;
               pass_v <= 1'b1;
               pass_w <= hold_w;
               pass_i <= hold_i;
            end else begin
               pass_v <= 1'b1;
               pass_w <= in_w;
               pass_i <= in_i;
            end
         end
      end
   end

endmodule

// File: rtl/sys_sorter.sv
module sys_sorter #(
   parameter int N_CELL = 65,
   parameter int W_BITS = 8,
   parameter int IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift,
   input  logic              in_v,
   input  logic [W_BITS-1:0] in_w,
   input  logic [IDX_W-1:0]  in_i,
   output logic              head_v,
   output logic [W_BITS-1:0] head_w,
   output logic [IDX_W-1:0]  head_i,
   output logic              moving
);

   logic [N_CELL-1:0] hv;
   logic [N_CELL-1:0] pv;
   logic [W_BITS-1:0] hw [N_CELL];
   logic [W_BITS-1:0] pw [N_CELL];
   logic [IDX_W-1:0]  hi [N_CELL];
   logic [IDX_W-1:0]  pi [N_CELL];

   for (genvar g = 0; g < N_CELL; g++) begin : g_cell
      logic              cv;
      logic [W_BITS-1:0] cw;
      logic [IDX_W-1:0]  ci;
      logic              nv;
      logic [W_BITS-1:0] nw;
      logic [IDX_W-1:0]  ni;

      if (g == 0) begin : g_entry
         assign cv = in_v;
         assign cw = in_w;
         assign ci = in_i;
      end else begin : g_chain
         assign cv = pv[g-1];
         assign cw = pw[g-1];
         assign ci = pi[g-1];
      end

      if (g == N_CELL - 1) begin : g_tail
         assign nv = 1'b0;
         assign nw = '0;
         assign ni = '0;
      end else begin : g_link
         assign nv = hv[g+1];
         assign nw = hw[g+1];
         assign ni = hi[g+1];
      end

      sort_cell #(
         .W_BITS(W_BITS),
         .IDX_W (IDX_W)
      ) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .clr    (clr),
         .shift  (shift),
         .in_v   (cv),
         .in_w   (cw),
         .in_i   (ci),
         .nb_v   (nv),
         .nb_w   (nw),
         .nb_i   (ni),
         .hold_v (hv[g]),
         .hold_w (hw[g]),
         .hold_i (hi[g]),
         .pass_v (pv[g]),
         .pass_w (pw[g]),
         .pass_i (pi[g])
      );
   end

   always_comb begin
      head_v = hv[0];
      head_w = hw[0];
      head_i = hi[0];
      moving = |pv;
   end

endmodule

// File: rtl/tour_ctrl.sv
module tour_ctrl
   import tour_pkg::*;
#(
   parameter int N_CITY = 65,
   parameter int W_BITS = 8,
   parameter int C_BITS = 8,
   localparam int IDX_W = $clog2(N_CITY),
   localparam int ACC_W = C_BITS + $clog2(N_CITY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   input  logic [W_BITS-1:0] in_weight,
   output logic              s_clr,
   output logic              s_shift,
   output logic              s_in_v,
   output logic [W_BITS-1:0] s_in_w,
   output logic [IDX_W-1:0]  s_in_i,
   input  logic              head_v,
   input  logic [W_BITS-1:0] head_w,
   input  logic [IDX_W-1:0]  head_i,
   output logic              rd_en,
   output logic [IDX_W-1:0]  rd_from,
   output logic [IDX_W-1:0]  rd_to,
   input  logic [C_BITS-1:0] rd_data,
   output logic              busy,
   output logic              done,
   output logic              ord_valid,
   output logic [IDX_W-1:0]  ord_city,
   output logic [W_BITS-1:0] ord_weight,
   output logic [IDX_W-1:0]  ord_pos,
   output logic [ACC_W-1:0]  total_cost
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CITY - 1);

   tour_state_t      state;
   logic [IDX_W-1:0] cnt;
   logic [IDX_W-1:0] prev_city;
   logic [IDX_W-1:0] first_city;
   logic             rd_pend;
   logic [ACC_W-1:0] acc;

   always_comb begin
      s_clr      = (state == ST_IDLE) && start;
      s_shift    = (state == ST_EMIT);
      s_in_v     = (state == ST_LOAD) && in_valid;
      s_in_w     = in_weight;
      s_in_i     = cnt;
      ord_valid  = (state == ST_EMIT) && head_v;
      ord_city   = head_i;
      ord_weight = head_w;
      ord_pos    = cnt;
      rd_en      = ((state == ST_EMIT) && (cnt != '0)) || (state == ST_CLOSE);
      rd_from    = prev_city;
      rd_to      = (state == ST_CLOSE) ? first_city : head_i;
      busy       = (state != ST_IDLE);
      done       = (state == ST_FIN);
      total_cost = acc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cnt        <= '0;
         prev_city  <= '0;
         first_city <= '0;
         rd_pend    <= 1'b0;
         acc        <= '0;
      end else begin
         rd_pend <= rd_en;
         if (rd_pend) begin
            acc <= acc + ACC_W'(rd_data);
         end
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_LOAD;
                  cnt     <= '0;
                  acc     <= '0;
                  rd_pend <= 1'b0;
               end
            end
            ST_LOAD: begin
               if (in_valid) begin
                  if (cnt == LAST) begin
                     cnt   <= '0;
                     state <= ST_SETTLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            ST_SETTLE: begin
               if (cnt == LAST) begin
                  cnt   <= '0;
                  state <= ST_EMIT;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_EMIT: begin
               prev_city <= head_i;
               if (cnt == '0) begin
                  first_city <= head_i;
               end
               if (cnt == LAST) begin
                  cnt   <= '0;
                  state <= ST_CLOSE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_CLOSE: state <= ST_DRAIN;
            ST_DRAIN: state <= ST_FIN;
            ST_FIN:   state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/weight_tour_eval.sv
module weight_tour_eval #(
   parameter int N_CITY = 65,
   parameter int W_BITS = 8,
   parameter int C_BITS = 8,
   localparam int IDX_W = $clog2(N_CITY),
   localparam int ACC_W = C_BITS + $clog2(N_CITY + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              in_valid,
   input  logic [W_BITS-1:0] in_weight,
   output logic              busy,
   output logic              cost_rd_en,
   output logic [IDX_W-1:0]  cost_from,
   output logic [IDX_W-1:0]  cost_to,
   input  logic [C_BITS-1:0] cost_rd_data,
   output logic              ord_valid,
   output logic [IDX_W-1:0]  ord_city,
   output logic [W_BITS-1:0] ord_weight,
   output logic [IDX_W-1:0]  ord_pos,
   output logic              done,
   output logic [ACC_W-1:0]  total_cost
);

   if (N_CITY < 2) begin : g_bad_cities
      $error("weight_tour_eval: N_CITY must be at least 2");
   end
   if (W_BITS < 1 || C_BITS < 1) begin : g_bad_widths
      $error("weight_tour_eval: W_BITS and C_BITS must be positive");
   end

   logic              s_clr;
   logic              s_shift;
   logic              s_in_v;
   logic [W_BITS-1:0] s_in_w;
   logic [IDX_W-1:0]  s_in_i;
   logic              head_v;
   logic [W_BITS-1:0] head_w;
   logic [IDX_W-1:0]  head_i;
   logic              sort_moving;

   sys_sorter #(
      .N_CELL(N_CITY),
      .W_BITS(W_BITS),
      .IDX_W (IDX_W)
   ) u_sorter (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (s_clr),
      .shift  (s_shift),
      .in_v   (s_in_v),
      .in_w   (s_in_w),
      .in_i   (s_in_i),
      .head_v (head_v),
      .head_w (head_w),
      .head_i (head_i),
      .moving (sort_moving)
   );

   tour_ctrl #(
      .N_CITY(N_CITY),
      .W_BITS(W_BITS),
      .C_BITS(C_BITS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .in_valid   (in_valid),
      .in_weight  (in_weight),
      .s_clr      (s_clr),
      .s_shift    (s_shift),
      .s_in_v     (s_in_v),
      .s_in_w     (s_in_w),
      .s_in_i     (s_in_i),
      .head_v     (head_v),
      .head_w     (head_w),
      .head_i     (head_i),
      .rd_en      (cost_rd_en),
      .rd_from    (cost_from),
      .rd_to      (cost_to),
      .rd_data    (cost_rd_data),
      .busy       (busy),
      .done       (done),
      .ord_valid  (ord_valid),
      .ord_city   (ord_city),
      .ord_weight (ord_weight),
      .ord_pos    (ord_pos),
      .total_cost (total_cost)
   );

endmodule

// File: rtl/tour_eval_chk.sv
module tour_eval_chk #(
   parameter int N_CITY = 65,
   parameter int W_BITS = 8,
   parameter int C_BITS = 8,
   localparam int IDX_W = $clog2(N_CITY),
   localparam int ACC_W = C_BITS + $clog2(N_CITY + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              ord_valid,
   input logic [IDX_W-1:0]  ord_city,
   input logic [W_BITS-1:0] ord_weight,
   input logic [IDX_W-1:0]  ord_pos,
   input logic              cost_rd_en,
   input logic [IDX_W-1:0]  cost_from,
   input logic [IDX_W-1:0]  cost_to,
   input logic [ACC_W-1:0]  total_cost,
   input logic              sort_moving
);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ord_valid && !cost_rd_en && !done)); // R1

   AST_ORDER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_valid && $past(ord_valid)) |->
         (($past(ord_weight) < ord_weight) ||
          (($past(ord_weight) == ord_weight) && ($past(ord_city) < ord_city)))); // R3

   AST_SORT_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
      ord_valid |-> !sort_moving); // R3

   AST_RANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ord_valid && $past(ord_valid)) |-> (ord_pos == $past(ord_pos) + 1'b1)); // R4

   AST_RANK_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ord_valid) |-> (ord_pos == '0)); // R4

   AST_READ_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (cost_rd_en && $past(cost_rd_en)) |-> (cost_from == $past(cost_to))); // R5

   AST_CLOSING_LEG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ord_valid) |-> cost_rd_en); // R6

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (total_cost >= $past(total_cost))); // R7

endmodule

bind weight_tour_eval tour_eval_chk #(
   .N_CITY(N_CITY),
   .W_BITS(W_BITS),
   .C_BITS(C_BITS)
) u_chk (.*);

// File: tb/weight_tour_eval_test.sv
`timescale 1ns/1ps
module weight_tour_eval_test;

   localparam int N   = 65;
   localparam int WB  = 8;
   localparam int CB  = 8;
   localparam int IW  = $clog2(N);
   localparam int AW  = CB + $clog2(N + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          in_valid = 1'b0;
   logic [WB-1:0] in_weight = '0;
   logic          busy;
   logic          cost_rd_en;
   logic [IW-1:0] cost_from;
   logic [IW-1:0] cost_to;
   logic [CB-1:0] cost_rd_data = '0;
   logic          ord_valid;
   logic [IW-1:0] ord_city;
   logic [WB-1:0] ord_weight;
   logic [IW-1:0] ord_pos;
   logic          done;
   logic [AW-1:0] total_cost;

   weight_tour_eval #(.N_CITY(N), .W_BITS(WB), .C_BITS(CB)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_weight(in_weight), .busy(busy), .cost_rd_en(cost_rd_en),
      .cost_from(cost_from), .cost_to(cost_to), .cost_rd_data(cost_rd_data),
      .ord_valid(ord_valid), .ord_city(ord_city), .ord_weight(ord_weight),
      .ord_pos(ord_pos), .done(done), .total_cost(total_cost)
   );

   always #2.5 clk = ~clk;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  finished = 1'b0;
   bit  max_mode = 1'b0;
   int  wts [N];
   int  got_city [N];
   int  got_pos [N];
   int  rd_f [N+1];
   int  rd_t [N+1];
   int  mon_n = 0;
   int  rd_n = 0;

   function automatic int cost_of(input int f, input int t);
      if (max_mode) return 255;
      return (f * 73 + t * 29 + (f ^ t) * 5 + 11) % 256;
   endfunction

   always @(posedge clk) begin
      if (cost_rd_en) cost_rd_data <= CB'(cost_of(int'(cost_from), int'(cost_to)));
   end

   always @(negedge clk) begin
      if (ord_valid) begin
         if (mon_n < N) begin
            got_city[mon_n] = int'(ord_city);
            got_pos[mon_n]  = int'(ord_pos);
         end
         mon_n++;
      end
      if (cost_rd_en) begin
         if (rd_n < N + 1) begin
            rd_f[rd_n] = int'(cost_from);
            rd_t[rd_n] = int'(cost_to);
         end
         rd_n++;
      end
   end

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_case(input string name, input int gaps, input bit poke, input string req_tot);
      int exp_ord [N];
      int bad;
      int t;
      longint exp_tot;
      for (int i = 0; i < N; i++) exp_ord[i] = i;
      for (int i = 1; i < N; i++) begin
         for (int j = i; j > 0; j--) begin
            if (wts[exp_ord[j]] < wts[exp_ord[j-1]]) begin
               int tmp = exp_ord[j];
               exp_ord[j] = exp_ord[j-1];
               exp_ord[j-1] = tmp;
            end
         end
      end
      exp_tot = cost_of(exp_ord[N-1], exp_ord[0]);
      for (int k = 1; k < N; k++) exp_tot += cost_of(exp_ord[k-1], exp_ord[k]);

      // stray strobes while idle must be ignored (R2)
      in_valid = 1'b1; in_weight = '0;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      mon_n = 0; rd_n = 0;
      start = 1'b1; @(negedge clk); start = 1'b0;
      for (int i = 0; i < N; i++) begin
         int g = (gaps > 0) ? int'($urandom_range(gaps, 0)) : 0;
         repeat (g) @(negedge clk);
         in_valid = 1'b1; in_weight = WB'(wts[i]);
         @(negedge clk);
         in_valid = 1'b0;
         if (poke && i == N / 2) begin
            start = 1'b1; @(negedge clk); start = 1'b0;
         end
      end
      t = 0;
      while (!done && t < 2000) begin @(negedge clk); t++; end
      chk("R7", {name, " done seen"}, done, 1);
      chk(req_tot, {name, " total"}, total_cost, exp_tot);
      chk("R2", {name, " stream length"}, mon_n, N);
      bad = 0;
      for (int k = 0; k < N; k++) if (got_city[k] != exp_ord[k]) bad++;
      chk("R3", {name, " order mismatches"}, bad, 0);
      bad = 0;
      for (int k = 0; k < N; k++) if (got_pos[k] != k) bad++;
      chk("R4", {name, " position mismatches"}, bad, 0);
      chk("R5", {name, " read count"}, rd_n, N);
      bad = 0;
      for (int k = 0; k < N - 1; k++)
         if (rd_f[k] != exp_ord[k] || rd_t[k] != exp_ord[k+1]) bad++;
      chk("R5", {name, " leg read mismatches"}, bad, 0);
      chk("R6", {name, " closing from"}, rd_f[N-1], exp_ord[N-1]);
      chk("R6", {name, " closing to"}, rd_t[N-1], exp_ord[0]);
      @(negedge clk);
      chk("R7", {name, " done one cycle"}, done, 0);
      repeat (3) @(negedge clk);
      chk("R7", {name, " total held"}, total_cost, exp_tot);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      chk("R1", "busy after reset", busy, 0);
      chk("R1", "done after reset", done, 0);
      chk("R1", "ord_valid after reset", ord_valid, 0);
      chk("R1", "cost_rd_en after reset", cost_rd_en, 0);
      chk("R1", "total after reset", total_cost, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", "busy idle", busy, 0);

      // directed: example weights, padding ties at 255
      for (int i = 0; i < N; i++) wts[i] = 255;
      wts[0] = 25; wts[1] = 17; wts[2] = 10; wts[3] = 20;
      wts[4] = 55; wts[5] = 5;  wts[6] = 70; wts[7] = 13;
      run_case("example", 0, 1'b0, "R7");
      begin
         int exp_rank [8] = '{5, 3, 1, 4, 6, 0, 7, 2};
         int bad = 0;
         for (int c = 0; c < 8; c++) begin
            int r = -1;
            for (int k = 0; k < N; k++) if (got_city[k] == c) r = got_pos[k];
            if (r != exp_rank[c]) bad++;
         end
         chk("R4", "example rank mismatches", bad, 0);
         chk("R3", "example first city", got_city[0], 5);
      end

      for (int i = 0; i < N; i++) wts[i] = 100;
      run_case("all equal", 1, 1'b0, "R7");

      for (int i = 0; i < N; i++) wts[i] = 255 - 3 * i;
      run_case("descending", 2, 1'b0, "R7");

      for (int i = 0; i < N; i++) wts[i] = int'($urandom_range(3, 0));
      run_case("dense ties", 3, 1'b0, "R7");

      for (int i = 0; i < N; i++) wts[i] = int'($urandom_range(255, 0));
      run_case("random", 3, 1'b0, "R7");

      for (int i = 0; i < N; i++) wts[i] = int'($urandom_range(255, 0));
      run_case("start while busy", 2, 1'b1, "R8");

      max_mode = 1'b1;
      for (int i = 0; i < N; i++) wts[i] = int'($urandom_range(255, 0));
      run_case("max cost", 0, 1'b0, "R7");
      chk("R7", "max cost no overflow", total_cost, 255 * N);
      max_mode = 1'b0;

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule